// File: doc/BRIEF.md
# Authorized Scratchpad Copy Engine

This block carries out the copy-scratchpad command of a small serial-bus memory. It watches the byte stream that the bit-level front end delivers after a bus reset. If the first byte is the copy opcode 55h, it collects a three-byte echo of the target-address and end/status registers, which the master read back earlier. The copy is accepted only when all of these hold:

- the echo matches byte for byte;
- the target lies inside the writable range;
- the partial-write flag is clear;
- the target is not locked.

On acceptance the block raises the authorization flag and commits the eight scratchpad bytes to the aligned memory row in one write. It then holds a programming-busy interval of a fixed cycle count.

After the interval the block presents a status byte to the master until the next bus reset. The byte is an alternating-bit pattern after a clean copy. It is solid ones after a rejected command or after a power failure during programming. The scratchpad contents, the address registers and the storage array all live outside the block. It only reads them and drives the write strobe.

Top module: `scratch_commit`

## Requirements
- R1: In idle, a received first byte other than 55h makes the block ignore every byte until `bus_reset`: no write, `aa` unchanged, and `tx_byte` stays FFh.
- R2: After 55h, the next three bytes must equal `ta[7:0]`, `ta[15:8]` and `es`, in that order. Any mismatch, including a right byte in the wrong position, rejects the copy: no write, `aa` unchanged, and `tx_byte` is FFh until `bus_reset`.
- R3: A matching echo whose target `ta` is not below `ADDR_LIMIT` (default 0090h) is rejected as in R2. A target of 008Fh is accepted.
- R4: A matching echo is rejected as in R2 when `pf` or `cp_lock` is high at the third byte, and `aa` stays clear.
- R5: An accepted copy gives one `wr_en` pulse on the clock after the third byte. In the same cycle `aa` goes high, `wr_row` equals `ta[15:3]` (the row is aligned, the low three address bits are dropped) and `wr_data` equals `pad_data`.
- R6: `prog_busy` is high for exactly `PROG_CYC` cycles, starting with the `wr_en` cycle. A `bus_reset` during that interval is ignored.
- R7: When programming ends without a power failure, `tx_byte` is AAh until `bus_reset`. AAh is the alternating pattern 0,1,0,1… sent least significant bit first.
- R8: `pwr_fail` high during programming ends the interval on the next clock, and `tx_byte` is FFh from then until `bus_reset`.
- R9: Outside the programming interval, `bus_reset` returns the block to idle. In idle, and while a command is being received, `tx_byte` is FFh.
- R10: `aa` is cleared by a `pad_wr` pulse and reset low. When a set and a clear fall in the same cycle, the set wins.
- R11: Bytes received while programming or while a result pattern is shown have no effect on `tx_byte`, `wr_en` or `aa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | One-cycle strobe: master issued a bus reset |
| rx_valid | input | 1 | A byte from the master is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte the master reads: FFh or AAh |
| ta | input | ADDR_W | Stored target address register |
| es | input | 8 | Stored end/status register |
| pf | input | 1 | Partial-write flag |
| cp_lock | input | 1 | Target area is copy protected |
| pad_data | input | PAD_BYTES*8 | Scratchpad contents, byte 0 in the low bits |
| pad_wr | input | 1 | Scratchpad written: clears `aa` |
| aa | output | 1 | Authorization-accepted flag |
| wr_en | output | 1 | Row write strobe to memory |
| wr_row | output | ADDR_W-3 | Row index of the write |
| wr_data | output | PAD_BYTES*8 | Row data of the write |
| prog_busy | output | 1 | Programming interval running |
| pwr_fail | input | 1 | Supply dropped during programming |

## Verification
All outputs are registered from the command state. A wrong state therefore shows at the ports on the clock after the event that caused it. A missed or extra accept shows as a wrong `wr_en`/`aa` pulse. An off-by-one in the programming counter shows as `prog_busy` falling a cycle early or late. A wrong result state shows as AAh in place of FFh, or the other way round. The reference model runs alongside the design and is compared every cycle, so each such divergence is reported within one clock of its cause.

// File: rtl/scratch_commit.sv
module scratch_commit #(
  parameter int ADDR_W     = 16,
  parameter int PAD_BYTES  = 8,
  parameter int ADDR_LIMIT = 16'h0090,
  parameter int PROG_CYC   = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_reset,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  output logic [7:0]             tx_byte,
  input  logic [ADDR_W-1:0]      ta,
  input  logic [7:0]             es,
  input  logic                   pf,
  input  logic                   cp_lock,
  input  logic [PAD_BYTES*8-1:0] pad_data,
  input  logic                   pad_wr,
  output logic                   aa,
  output logic                   wr_en,
  output logic [ADDR_W-4:0]      wr_row,
  output logic [PAD_BYTES*8-1:0] wr_data,
  output logic                   prog_busy,
  input  logic                   pwr_fail
);
  localparam int CNT_W = $clog2(PROG_CYC + 1);
  localparam logic [7:0] OPC = 8'h55;

  typedef enum logic [2:0] {S_IDLE, S_AUTH, S_PROG, S_OK, S_FAIL, S_SKIP} st_t;

  st_t              st;
  logic [1:0]       idx;
  logic             mism;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       want;
  logic             accept;

  assign want = (idx == 2'd0) ? ta[7:0] : (idx == 2'd1) ? ta[15:8] : es;
  assign accept = !mism && rx_byte == want && ta < ADDR_W'(ADDR_LIMIT) && !pf && !cp_lock;

  assign tx_byte   = (st == S_OK) ? 8'hAA : 8'hFF;
  assign prog_busy = (st == S_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      mism    <= 1'b0;
      cnt     <= '0;
      aa      <= 1'b0;
      wr_en   <= 1'b0;
      wr_row  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (pad_wr) aa <= 1'b0;
      case (st)
        S_IDLE:
          if (bus_reset) st <= S_IDLE;
          else if (rx_valid) begin
            st   <= (rx_byte == OPC) ? S_AUTH : S_SKIP;
            idx  <= '0;
            mism <= 1'b0;
          end
        S_AUTH:
          if (bus_reset) st <= S_IDLE;
          else if (rx_valid) begin
            if (idx == 2'd2) begin
              if (accept) begin
                st      <= S_PROG;
                cnt     <= CNT_W'(PROG_CYC - 1);
                wr_en   <= 1'b1;
                wr_row  <= ta[ADDR_W-1:3];
                wr_data <= pad_data;
                aa      <= 1'b1;
              end else begin
                st <= S_FAIL;
              end
            end else begin
              idx  <= idx + 2'd1;
              mism <= mism | (rx_byte != want);
            end
          end
        S_PROG:
          if (pwr_fail) st <= S_FAIL;
          else if (cnt == '0) st <= S_OK;
          else cnt <= cnt - 1'b1;
        default:
          if (bus_reset) st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scratch_commit_chk.sv
module scratch_commit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       pwr_fail,
  input logic       wr_en,
  input logic       aa,
  input logic       prog_busy,
  input logic [7:0] tx_byte
);
  // R5
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R5
  wr_sets_aa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> aa);
  // R6
  wr_starts_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> prog_busy);
  // R6
  prog_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && !pwr_fail) |=> (prog_busy || tx_byte == 8'hAA));
  // R8
  pwr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && pwr_fail) |=> (!prog_busy && tx_byte == 8'hFF));
  // R9
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !prog_busy) |=> tx_byte == 8'hFF);
  // R7
  tx_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_byte == 8'hAA || tx_byte == 8'hFF));
endmodule

bind scratch_commit scratch_commit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .pwr_fail(pwr_fail),
  .wr_en(wr_en), .aa(aa), .prog_busy(prog_busy), .tx_byte(tx_byte)
);

// File: tb/test_scratch_commit.sv
module test_scratch_commit;
  localparam int PROG_CYC = 20;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_reset = 0, rx_valid = 0, pf = 0, cp_lock = 0, pad_wr = 0, pwr_fail = 0;
  logic [7:0]  rx_byte = 0, es = 8'h07;
  logic [15:0] ta = 16'h0048;
  logic [63:0] pad_data = 64'h0123_4567_89AB_CDEF;
  logic [7:0]  tx_byte;
  logic        aa, wr_en, prog_busy;
  logic [12:0] wr_row;
  logic [63:0] wr_data;

  always #2 clk = ~clk;

  scratch_commit #(.PROG_CYC(PROG_CYC)) i_scratch_commit (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_byte(tx_byte), .ta(ta), .es(es), .pf(pf),
    .cp_lock(cp_lock), .pad_data(pad_data), .pad_wr(pad_wr), .aa(aa),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data), .prog_busy(prog_busy),
    .pwr_fail(pwr_fail)
  );

  int checks = 0, fails = 0, cyc = 0;
  string req = "R9";

  // reference model: 0 idle, 1 echo, 2 programming, 3 success, 4 all-ones, 5 skipping
  int phase = 0, got = 0, remain = 0;
  bit bad = 0, m_aa = 0, m_wr = 0;
  int m_row = 0;
  logic [63:0] m_data = 0;
  logic [7:0] q[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      phase = 0; m_aa = 0; m_wr = 0;
    end else begin
      m_wr = 0;
      if (pad_wr) m_aa = 0;
      if (phase == 2) begin
        if (pwr_fail) phase = 4;
        else if (remain == 1) phase = 3;
        else remain--;
      end else if (bus_reset) phase = 0;
      else if (rx_valid) begin
        if (phase == 0) begin
          phase = (rx_byte == 8'h55) ? 1 : 5;
          got = 0; bad = 0;
          q = {ta[7:0], ta[15:8], es};
        end else if (phase == 1) begin
          if (rx_byte != q[got]) bad = 1;
          got++;
          if (got == 3) begin
            if (!bad && ta < 16'h0090 && !pf && !cp_lock) begin
              phase = 2; remain = PROG_CYC; m_wr = 1; m_aa = 1;
              m_row = int'(ta) >> 3; m_data = pad_data;
            end else phase = 4;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] etx;
      etx = (phase == 3) ? 8'hAA : 8'hFF;
      checks++;
      if (tx_byte !== etx || aa !== m_aa || wr_en !== m_wr || prog_busy !== (phase == 2) ||
          (m_wr && (int'(wr_row) != m_row || wr_data !== m_data))) begin
        fails++;
        $display("FAIL %s cyc %0d: tx=%h/%h aa=%b/%b wr=%b/%b busy=%b/%b row=%0d/%0d data=%h/%h",
                 req, cyc, tx_byte, etx, aa, m_aa, wr_en, m_wr, prog_busy, phase == 2,
                 wr_row, m_row, wr_data, m_data);
      end
    end
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  task automatic direct(input string r, input bit cond);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s direct: tx=%h aa=%b busy=%b", r, tx_byte, aa, prog_busy);
    end
  endtask

  task automatic copy(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    send(8'h55); send(a); send(b); send(c);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    req = "R9"; direct("R9", tx_byte == 8'hFF && !aa && !wr_en);

    req = "R1"; send(8'hF0); send(8'h48); send(8'h00); send(8'h07); idle(3);
    direct("R1", tx_byte == 8'hFF && !aa); breset();

    req = "R5"; copy(8'h48, 8'h00, 8'h07);
    req = "R6"; idle(3); breset(); send(8'h33); idle(PROG_CYC);
    req = "R7"; direct("R7", tx_byte == 8'hAA && aa);
    req = "R11"; copy(8'h48, 8'h00, 8'h07); idle(2);
    direct("R11", tx_byte == 8'hAA);
    req = "R9"; breset(); idle(1); direct("R9", tx_byte == 8'hFF);

    req = "R10"; @(negedge clk); pad_wr = 1; @(negedge clk); pad_wr = 0;
    idle(1); direct("R10", !aa);

    req = "R2"; copy(8'h00, 8'h48, 8'h07); idle(2); direct("R2", tx_byte == 8'hFF && !aa); breset();
    copy(8'h48, 8'h00, 8'h06); idle(2); direct("R2", !aa); breset();

    req = "R3"; ta = 16'h0090; copy(8'h90, 8'h00, 8'h07); idle(2);
    direct("R3", !aa && tx_byte == 8'hFF); breset();
    ta = 16'h008F; copy(8'h8F, 8'h00, 8'h07); idle(PROG_CYC + 2);
    direct("R3", aa && tx_byte == 8'hAA); breset();
    @(negedge clk); pad_wr = 1; @(negedge clk); pad_wr = 0;

    req = "R4"; ta = 16'h0010; pf = 1; copy(8'h10, 8'h00, 8'h07); idle(2);
    direct("R4", !aa); pf = 0; breset();
    cp_lock = 1; copy(8'h10, 8'h00, 8'h07); idle(2);
    direct("R4", !aa && tx_byte == 8'hFF); cp_lock = 0; breset();

    req = "R8"; pad_data = 64'hFEDC_BA98_7654_3210; copy(8'h10, 8'h00, 8'h07); idle(5);
    @(negedge clk); pwr_fail = 1; @(negedge clk); pwr_fail = 0;
    idle(PROG_CYC); direct("R8", tx_byte == 8'hFF && !prog_busy); breset();

    req = "R10"; @(negedge clk); pad_wr = 1; @(negedge clk); pad_wr = 0; idle(1);
    direct("R10", !aa);
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule